// File: doc/BRIEF.md
# Synchronizable Sinc Decimation Filter

This block sits behind a successive-approximation converter core. It takes one signed sample each time `smp_vld` is high and runs the stream through a cascade of integrators and combs (a sinc filter of configurable order). The stream is downsampled by a power-of-two factor. Once per decimation period it delivers a 32-bit two's-complement word on `fil_data`. The output is scaled so that a full-scale input gives a full-scale word. An active-low one-clock strobe, `fil_rdy_n`, marks each new word.

A pulse on `sync_in` restarts the decimation phase and clears the whole filter state. Several instances that share the sample strobe and receive the same pulse therefore emit words on the same sample. The factor (as a base-2 logarithm) and the order come in on configuration inputs. A new value is adopted only at a pulse on `sync_in` or at the end of a decimation period, and never part-way through an accumulation. After any restart, no word is emitted until the filter has seen order × factor fresh samples.

Top module: `sinc_decim`

## Requirements
- R1: While reset is asserted and until the first word, `fil_rdy_n` is 1 and `fil_data` is 0.
- R2: With a constant input x held since the last restart, every word equals x × 2^(OUT_W−IN_W), for every order and factor. This maps −2^23 to 0x80000000 and 2^23−1 to 0x7FFFFF00.
- R3: At order 1 with factor DF = 2^L, each word equals (the sum of that period's DF samples) × 2^(OUT_W−IN_W) arithmetically shifted right by L, rounded toward minus infinity.
- R4: After settling, the block emits exactly one word per DF accepted samples, and two strobes are always at least 4 clocks apart.
- R5: After a restart, the first word comes out for the (order × DF)-th accepted sample, and no word comes out before it.
- R6: `fil_rdy_n` is low for exactly one clock. Its low cycle and the new `fil_data` appear MAX_ORD+1 clock edges after the edge that accepts the sample closing the period.
- R7: A cycle with `sync_in` high clears the filter and the phase counter. A sample presented in that same cycle becomes sample 0 of the new period, and samples of the interrupted period do not contribute to any later word.
- R8: A configuration that differs from the active one is adopted at the next period boundary. That boundary emits no word and starts a new settling interval, and later samples are filtered with the new factor and order.
- R9: A factor code below MIN_LOG or above MAX_LOG is treated as MIN_LOG or MAX_LOG. An order code of 0 is treated as 1, and one above MAX_ORD is treated as MAX_ORD.
- R10: `fil_data` changes only in a cycle where `fil_rdy_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| smp_vld | input | 1 | Sample strobe from the converter core |
| smp_data | input | IN_W | Signed converter sample |
| sync_in | input | 1 | Phase realignment pulse; clears the filter state |
| cfg_log_df | input | LOGW | Base-2 logarithm of the decimation factor |
| cfg_order | input | ORDW | Filter order, 1 to MAX_ORD |
| fil_data | output | OUT_W | Filtered two's-complement word |
| fil_rdy_n | output | 1 | Active-low one-clock strobe for a new word |

## Verification
A word is due MAX_ORD+1 clock edges after the edge that accepts the last sample of its period. The bench drives every input on the falling edge and logs `fil_rdy_n` and `fil_data` on the falling edge, together with a cycle count. The latency check therefore compares a logged strobe cycle with the logged drive cycle of the closing sample, and expects a gap of MAX_ORD+2 falling edges. Count checks for the settling interval, the rate and the ignored cases wait eight idle clocks after the last stimulus, which is longer than the pipeline, before they compare word counts.

// File: rtl/sinc_pkg.sv
`timescale 1ns/1ps
package sinc_pkg;

  // Tag that travels with a decimation event down the comb pipeline
  typedef struct packed {
    logic fire;   // a period boundary happened
    logic emit;   // filter settled: the result is published
  } dec_tag_t;

  function automatic int unsigned clip(int unsigned v, int unsigned lo, int unsigned hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

endpackage

// File: rtl/sinc_ctrl.sv
`timescale 1ns/1ps
module sinc_ctrl
  import sinc_pkg::*;
#(
  parameter int MIN_LOG = 2,
  parameter int MAX_LOG = 14,
  parameter int MAX_ORD = 4,
  parameter int LOGW    = 4,
  parameter int ORDW    = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               smp_vld,
  input  logic               sync_in,
  input  logic [LOGW-1:0]    cfg_log,
  input  logic [ORDW-1:0]    cfg_ord,
  output logic [LOGW-1:0]    log_q,
  output logic [ORDW-1:0]    ord_q,
  output logic [MAX_LOG-1:0] ph_q,
  output logic               clr,
  output logic               keep_first,
  output dec_tag_t           tag_q
);

  logic [LOGW-1:0]    log_c, log_d;
  logic [ORDW-1:0]    ord_c, ord_d;
  logic [MAX_LOG-1:0] ph_d, mask;
  logic [ORDW-1:0]    settle_q, settle_d;
  dec_tag_t           tag_d;
  logic               at_edge, cfg_diff, cfg_restart, fire, emit;

  // next-state logic
  always_comb begin
    log_c = LOGW'(clip(int'(cfg_log), MIN_LOG, MAX_LOG));
    ord_c = ORDW'(clip(int'(cfg_ord), 1, MAX_ORD));
    mask  = MAX_LOG'((32'd1 << log_q) - 32'd1);

    at_edge     = smp_vld && (ph_q == mask);
    cfg_diff    = (log_c != log_q) || (ord_c != ord_q);
    cfg_restart = at_edge && cfg_diff;
    clr         = sync_in || cfg_restart;
    keep_first  = sync_in && smp_vld;
    fire        = at_edge && !clr;
    emit        = fire && (((ORDW+1)'(settle_q) + (ORDW+1)'(1)) >= (ORDW+1)'(ord_q));

    ph_d = ph_q;
    if (sync_in)          ph_d = smp_vld ? MAX_LOG'(1) : '0;
    else if (cfg_restart) ph_d = '0;
    else if (smp_vld)     ph_d = at_edge ? '0 : ph_q + MAX_LOG'(1);

    settle_d = settle_q;
    if (clr)                                        settle_d = '0;
    else if (fire && (settle_q < ORDW'(MAX_ORD)))   settle_d = settle_q + ORDW'(1);

    log_d = clr ? log_c : log_q;
    ord_d = clr ? ord_c : ord_q;

    tag_d.fire = fire;
    tag_d.emit = emit;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= '0;
      settle_q <= '0;
      log_q    <= LOGW'(MIN_LOG);
      ord_q    <= ORDW'(1);
      tag_q    <= '0;
    end else begin
      ph_q     <= ph_d;
      settle_q <= settle_d;
      log_q    <= log_d;
      ord_q    <= ord_d;
      tag_q    <= tag_d;
    end
  end

endmodule

// File: rtl/sinc_integ.sv
`timescale 1ns/1ps
module sinc_integ #(
  parameter int IN_W    = 24,
  parameter int ACC_W   = 80,
  parameter int MAX_ORD = 4,
  parameter int ORDW    = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_vld,
  input  logic [IN_W-1:0]         smp_data,
  input  logic                    clr,
  input  logic                    keep_first,
  input  logic [ORDW-1:0]         ord,
  output logic signed [ACC_W-1:0] tap
);

  logic [ACC_W-1:0]                  x_ext;
  logic [MAX_ORD-1:0][ACC_W-1:0]     taps;

  assign x_ext = {{(ACC_W-IN_W){smp_data[IN_W-1]}}, smp_data};

  for (genvar i = 0; i < MAX_ORD; i++) begin : g_st
    logic [ACC_W-1:0] q, d, feed;
    logic             active, en;

    if (i == 0) begin : g_head
      assign feed = x_ext;
    end else begin : g_link
      assign feed = g_st[i-1].q;
    end

    always_comb begin
      active = (ORDW'(i) < ord);
      en     = clr || (smp_vld && active);
      d      = q;
      if (clr)                    d = (i == 0 && keep_first) ? x_ext : '0;
      else if (smp_vld && active) d = q + feed;   // wraps modulo 2^ACC_W
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end

    assign taps[i] = q;
  end

  always_comb begin
    tap = '0;
    for (int k = 0; k < MAX_ORD; k++)
      if (ord == ORDW'(k + 1)) tap = taps[k];
  end

endmodule

// File: rtl/sinc_comb.sv
`timescale 1ns/1ps
module sinc_comb
  import sinc_pkg::*;
#(
  parameter int IN_W    = 24,
  parameter int OUT_W   = 32,
  parameter int ACC_W   = 80,
  parameter int EXT_W   = 88,
  parameter int SH_W    = 6,
  parameter int MAX_ORD = 4,
  parameter int ORDW    = 3,
  parameter int LOGW    = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic signed [ACC_W-1:0] tap,
  input  dec_tag_t                tag,
  input  logic [ORDW-1:0]         ord,
  input  logic [LOGW-1:0]         log_df,
  output logic [OUT_W-1:0]        fil_data,
  output logic                    fil_rdy_n
);

  for (genvar i = 0; i < MAX_ORD; i++) begin : g_cs
    logic signed [ACC_W-1:0] in_v, c_q, c_d, dl_q, dl_d;
    dec_tag_t                in_t, t_q, t_d;
    logic                    active, en;

    if (i == 0) begin : g_head
      assign in_v = tap;
      assign in_t = tag;
    end else begin : g_link
      assign in_v = g_cs[i-1].c_q;
      assign in_t = g_cs[i-1].t_q;
    end

    always_comb begin
      active = (ORDW'(i) < ord);
      en     = clr || in_t.fire;
      c_d    = c_q;
      dl_d   = dl_q;
      t_d    = clr ? '0 : in_t;
      if (clr) begin
        dl_d = '0;
      end else if (in_t.fire) begin
        if (active) begin
          c_d  = in_v - dl_q;
          dl_d = in_v;
        end else begin
          c_d  = in_v;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        c_q  <= '0;
        dl_q <= '0;
        t_q  <= '0;
      end else begin
        t_q <= t_d;
        if (en) begin
          c_q  <= c_d;
          dl_q <= dl_d;
        end
      end
    end
  end

  logic signed [ACC_W-1:0] c_last;
  dec_tag_t                t_last;
  logic [SH_W-1:0]         sh;
  logic signed [EXT_W-1:0] ext_v, shr_v;
  logic [OUT_W-1:0]        data_d;
  logic                    pub, rdy_d;

  always_comb begin
    c_last = g_cs[MAX_ORD-1].c_q;
    t_last = g_cs[MAX_ORD-1].t_q;
    sh     = SH_W'(ord) * SH_W'(log_df);
    ext_v  = {{(EXT_W-ACC_W){c_last[ACC_W-1]}}, c_last} << (OUT_W-IN_W);
    shr_v  = ext_v >>> sh;
    pub    = t_last.fire && t_last.emit && !clr;
    data_d = pub ? shr_v[OUT_W-1:0] : fil_data;
    rdy_d  = !pub;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fil_data  <= '0;
      fil_rdy_n <= 1'b1;
    end else begin
      fil_rdy_n <= rdy_d;
      if (pub) fil_data <= data_d;
    end
  end

endmodule

// File: rtl/sinc_decim.sv
`timescale 1ns/1ps
module sinc_decim
  import sinc_pkg::*;
#(
  parameter int IN_W    = 24,
  parameter int OUT_W   = 32,
  parameter int MIN_LOG = 2,
  parameter int MAX_LOG = 14,
  parameter int MAX_ORD = 4,
  localparam int LOGW   = $clog2(MAX_LOG + 1),
  localparam int ORDW   = $clog2(MAX_ORD + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_vld,
  input  logic [IN_W-1:0]   smp_data,
  input  logic              sync_in,
  input  logic [LOGW-1:0]   cfg_log_df,
  input  logic [ORDW-1:0]   cfg_order,
  output logic [OUT_W-1:0]  fil_data,
  output logic              fil_rdy_n
);

  localparam int ACC_W = IN_W + MAX_ORD * MAX_LOG;
  localparam int EXT_W = ACC_W + OUT_W - IN_W;
  localparam int SH_W  = $clog2(MAX_ORD * MAX_LOG + 1);

  logic [LOGW-1:0]         log_w;
  logic [ORDW-1:0]         ord_w;
  logic [MAX_LOG-1:0]      ph_w;
  logic                    clr_w, keep_w;
  dec_tag_t                tag_w;
  logic signed [ACC_W-1:0] tap_w;

  sinc_ctrl #(
    .MIN_LOG(MIN_LOG), .MAX_LOG(MAX_LOG), .MAX_ORD(MAX_ORD),
    .LOGW(LOGW), .ORDW(ORDW)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .sync_in(sync_in),
    .cfg_log(cfg_log_df), .cfg_ord(cfg_order),
    .log_q(log_w), .ord_q(ord_w), .ph_q(ph_w),
    .clr(clr_w), .keep_first(keep_w), .tag_q(tag_w)
  );

  sinc_integ #(
    .IN_W(IN_W), .ACC_W(ACC_W), .MAX_ORD(MAX_ORD), .ORDW(ORDW)
  ) u_integ (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
    .clr(clr_w), .keep_first(keep_w), .ord(ord_w), .tap(tap_w)
  );

  sinc_comb #(
    .IN_W(IN_W), .OUT_W(OUT_W), .ACC_W(ACC_W), .EXT_W(EXT_W), .SH_W(SH_W),
    .MAX_ORD(MAX_ORD), .ORDW(ORDW), .LOGW(LOGW)
  ) u_comb (
    .clk(clk), .rst_n(rst_n), .clr(clr_w), .tap(tap_w), .tag(tag_w),
    .ord(ord_w), .log_df(log_w), .fil_data(fil_data), .fil_rdy_n(fil_rdy_n)
  );

endmodule

// File: rtl/sinc_decim_chk.sv
`timescale 1ns/1ps
module sinc_decim_chk #(
  parameter int OUT_W   = 32,
  parameter int MAX_LOG = 14,
  parameter int LOGW    = 4,
  parameter int ORDW    = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               smp_vld,
  input logic               sync_in,
  input logic [OUT_W-1:0]   fil_data,
  input logic               fil_rdy_n,
  input logic [MAX_LOG-1:0] ph,
  input logic [LOGW-1:0]    log_act,
  input logic [ORDW-1:0]    ord_act,
  input logic               clr
);

  // R6
  rdy_one_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fil_rdy_n |=> fil_rdy_n);

  // R4
  rdy_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fil_rdy_n |=> fil_rdy_n ##1 fil_rdy_n ##1 fil_rdy_n);

  // R10
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fil_data) |-> !fil_rdy_n);

  // R7
  sync_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_in |=> (ph == MAX_LOG'($past(smp_vld))));

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ($stable(log_act) && $stable(ord_act)));

endmodule

bind sinc_decim sinc_decim_chk #(
  .OUT_W(OUT_W), .MAX_LOG(MAX_LOG), .LOGW(LOGW), .ORDW(ORDW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .sync_in(sync_in),
  .fil_data(fil_data), .fil_rdy_n(fil_rdy_n), .ph(ph_w),
  .log_act(log_w), .ord_act(ord_w), .clr(clr_w)
);

// File: tb/sim_sinc_decim.sv
`timescale 1ns/1ps
module sim_sinc_decim;

  localparam int IN_W    = 24;
  localparam int OUT_W   = 32;
  localparam int MAX_ORD = 4;
  localparam int LAT     = MAX_ORD + 2;   // falling edges from drive to strobe

  logic              clk, rst_n, smp_vld, sync_in, fil_rdy_n;
  logic [IN_W-1:0]   smp_data;
  logic [3:0]        cfg_log_df;
  logic [2:0]        cfg_order;
  logic [OUT_W-1:0]  fil_data;

  int     n_chk, n_fail, cyc, drv_cyc, n_words, last_cyc;
  logic [OUT_W-1:0] last_word;

  sinc_decim u0 (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
    .sync_in(sync_in), .cfg_log_df(cfg_log_df), .cfg_order(cfg_order),
    .fil_data(fil_data), .fil_rdy_n(fil_rdy_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    n_words = 0; last_cyc = 0; last_word = '0;
  end
  always @(negedge clk)
    if (rst_n && !fil_rdy_n) begin
      n_words   = n_words + 1;
      last_word = fil_data;
      last_cyc  = cyc;
    end

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(logic v, longint x, logic s);
    @(negedge clk);
    smp_vld  = v;
    smp_data = IN_W'(x);
    sync_in  = s;
    drv_cyc  = cyc;
  endtask

  task automatic push(longint x); drive(1'b1, x, 1'b0); endtask
  task automatic idle(int n); repeat (n) drive(1'b0, 0, 1'b0); endtask

  task automatic restart(int l, int o);
    cfg_log_df = 4'(l);
    cfg_order  = 3'(o);
    drive(1'b0, 0, 1'b1);
    idle(8);
  endtask

  function automatic longint word_val();
    return longint'($signed(last_word));
  endfunction

  // R1
  task automatic t_reset();
    chk("R1 rdy_n in reset", fil_rdy_n, 1);
    chk("R1 data in reset", fil_data, 0);
    @(negedge clk); rst_n = 1'b1;
    idle(6);
    chk("R1 rdy_n after reset", n_words, 0);
    chk("R1 data after reset", fil_data, 0);
  endtask

  // R2 R5 R6 R4: constant input at every order, factor 4
  task automatic t_const_orders();
    for (int o = 1; o <= MAX_ORD; o++) begin
      longint x = o * 1000003 - 2500000;
      int base;
      restart(2, o);
      base = n_words;
      for (int k = 0; k < o * 4 - 1; k++) push(x);
      idle(8);
      chk("R5 no word before settling", n_words - base, 0);
      push(x);
      begin
        int d = drv_cyc;
        idle(8);
        chk("R5 first word at order*DF", n_words - base, 1);
        chk("R2 constant scaled", word_val(), x * 256);
        chk("R6 latency", last_cyc - d, LAT);
      end
      for (int k = 0; k < 4; k++) push(x);
      idle(8);
      chk("R4 next word after DF", n_words - base, 2);
      chk("R2 constant again", word_val(), x * 256);
    end
  endtask

  // R2: full scale to full scale
  task automatic t_full_scale();
    longint lim[2] = '{-8388608, 8388607};
    for (int j = 0; j < 2; j++) begin
      restart(4, 4);
      for (int k = 0; k < 64; k++) push(lim[j]);
      idle(8);
      chk("R2 full scale", word_val(), lim[j] * 256);
    end
  endtask

  // R3: order 1 window sums
  task automatic t_window();
    longint a[8] = '{1000, -2000, 300007, 5, -8388608, 8388607, -77, 12345};
    int base;
    restart(2, 1);
    base = n_words;
    for (int w = 0; w < 2; w++) begin
      longint s = 0;
      for (int k = 0; k < 4; k++) begin
        push(a[w*4+k]);
        s += a[w*4+k];
      end
      idle(8);
      chk("R3 window count", n_words - base, w + 1);
      chk("R3 window sum", word_val(), s * 64);
    end
  endtask

  // R4 R10: rate under continuous input, hold between words
  task automatic t_rate_hold();
    int base;
    logic [OUT_W-1:0] snap;
    restart(3, 2);
    base = n_words;
    for (int k = 0; k < 80; k++) push(-4242);
    idle(8);
    chk("R4 words for 80 samples", n_words - base, 9);
    snap = fil_data;
    base = n_words;
    idle(20);
    chk("R10 data held", fil_data, snap);
    chk("R10 no strobe while idle", n_words - base, 0);
  endtask

  // R7: sync mid-period with a coincident sample
  task automatic t_sync_align();
    int base;
    longint s;
    restart(2, 1);
    base = n_words;
    for (int k = 0; k < 3; k++) push(7000000);
    drive(1'b1, -111, 1'b1);
    s = -111;
    push(222); push(-333); push(4444);
    s += 222 - 333 + 4444;
    idle(8);
    chk("R7 one word after realign", n_words - base, 1);
    chk("R7 sum excludes old samples", word_val(), s * 64);
  endtask

  // R8: config change adopted at boundary only
  task automatic t_cfg_change();
    int base;
    longint s = 0;
    restart(2, 1);
    base = n_words;
    for (int k = 0; k < 4; k++) push(500);
    idle(8);
    chk("R8 word before change", n_words - base, 1);
    push(600); push(700);
    cfg_log_df = 4'd3;
    push(800); push(900);
    idle(8);
    chk("R8 boundary emits no word", n_words - base, 1);
    for (int k = 0; k < 8; k++) begin
      push(k * 1001 - 3000);
      s += k * 1001 - 3000;
    end
    idle(8);
    chk("R8 word under new factor", n_words - base, 2);
    chk("R8 value under new factor", word_val(), s * 32);
  endtask

  // R9: out-of-range codes clamp
  task automatic t_clamp();
    int base;
    restart(15, 0);
    base = n_words;
    for (int k = 0; k < 16383; k++) push(-1234567);
    idle(8);
    chk("R9 no word before 16384", n_words - base, 0);
    push(-1234567);
    idle(8);
    chk("R9 word at 16384", n_words - base, 1);
    chk("R9 value at max factor", word_val(), -1234567 * 256);
    restart(0, 7);
    base = n_words;
    for (int k = 0; k < 15; k++) push(3333333);
    idle(8);
    chk("R9 order clamped to max", n_words - base, 0);
    push(3333333);
    idle(8);
    chk("R9 word at 16 samples", n_words - base, 1);
    chk("R9 value clamped cfg", word_val(), 3333333 * 256);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; drv_cyc = 0;
    rst_n = 1'b0; smp_vld = 1'b0; smp_data = '0; sync_in = 1'b0;
    cfg_log_df = 4'd2; cfg_order = 3'd1;
    repeat (4) @(negedge clk);
    t_reset();
    t_const_orders();
    t_full_scale();
    t_window();
    t_rate_hold();
    t_sync_align();
    t_cfg_change();
    t_clamp();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule